// File: doc/BRIEF.md
# Block-Read Sequencer for a Synchronous 64-bit Bus

This block is the master side of a synchronous 64-bit bus that reads blocks of 32-bit words from a memory. A request gives a word start address and a block length of 4, 8, 12 or 16 words. The sequencer then runs a fixed schedule. First comes one address cycle. Next, the controller waits out the memory's initial access latency. After that it moves the block in groups of four words. Each group takes two one-cycle 64-bit beats, and a mandatory idle gap follows each group.

The memory reads each later group while the bus is busy with the previous group's beats and idle gap. Every group after the first therefore adds only the beats plus the gap. With the default parameters, a 4-word block takes 45 cycles and a 16-word block takes 57 cycles. The alternative of four separate 4-word reads would cost 180 cycles.

Read data is presented on a valid-only stream, one register stage after each bus beat. The stream has no back-pressure: the synchronous bus fixes one beat per cycle, so the consumer must take every beat in the cycle it appears. Control (start, busy, done, err) uses plain level and pulse pins.

Top module: `blkrd_ctrl`

## Requirements
- R1: After reset, busy, done, err, bus_addr_vld, bus_beat, out_valid and out_last are all low.
- R2: A start seen while idle with a legal length produces exactly one cycle of bus_addr_vld, in the cycle after start, with bus_addr equal to start_addr.
- R3: The first beat appears exactly 1 + LAT_CYC cycles after the address cycle (41 with defaults), counting the address cycle as offset 0.
- R4: Each four-word group is two beats in consecutive cycles. Beat k of a block carries the word address start_addr + 2k on bus_beat_addr, and bus_rdata[31:0] holds that word with the next word in bus_rdata[63:32].
- R5: At least IDLE_CYC cycles with bus_beat low (2 by default) separate consecutive groups, so group g begins at offset 1 + LAT_CYC + g*(2 + IDLE_CYC).
- R6: done is a one-cycle pulse on the final idle cycle. From the address cycle through the done cycle inclusive, a block takes 1 + LAT_CYC + (len/4)*(2 + IDLE_CYC) cycles: 45, 49, 53 and 57 for lengths 4, 8, 12 and 16.
- R7: A start asserted while busy is ignored. It causes no extra address cycle and does not change the beat timing or addresses of the block in progress.
- R8: A length that is not a multiple of 4, or that lies outside 4..16, raises err for one cycle in the cycle after start. It produces no address cycle and no beats, and busy stays low.
- R9: out_valid and out_data repeat bus_beat and bus_rdata one cycle later. out_last is high with the final beat of a block only.
- R10: busy is high from the address cycle through the done cycle, and low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| start_addr | input | ADDR_W | Word address of the first word |
| start_len | input | LEN_W | Block length in words |
| busy | output | 1 | Block in progress |
| done | output | 1 | Pulse on the final idle cycle |
| err | output | 1 | Pulse for an illegal length |
| bus_addr_vld | output | 1 | Address cycle strobe |
| bus_addr | output | ADDR_W | Block start address during the address cycle |
| bus_beat | output | 1 | Data beat strobe |
| bus_beat_addr | output | ADDR_W | Word address of the lower word of the current beat |
| bus_rdata | input | 2*WORD_W | Data returned by memory during a beat |
| out_valid | output | 1 | Read stream valid |
| out_data | output | 2*WORD_W | Read stream data |
| out_last | output | 1 | Final beat of the block |

## Verification
The hardest situation to reach is a new start request landing while a block is in flight, above all on the done cycle itself, when the block is about to finish but is still busy. The bench pokes start with random legal lengths on random cycles of every busy window, including the done cycle, and checks that no second address cycle appears. The memory model in the bench returns poison data for any group read before its overlapped access time has passed, so a schedule that moves a group too early shows up as wrong read data.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_GAP
  } blkrd_state_e;
endpackage

// File: rtl/blkrd_len_check.sv
module blkrd_len_check #(
  parameter int LEN_W       = 5,
  parameter int GROUP_WORDS = 4,
  parameter int MIN_WORDS   = 4,
  parameter int MAX_WORDS   = 16,
  parameter int GRP_W       = 3
) (
  input  logic [LEN_W-1:0] len,
  output logic             len_ok,
  output logic [GRP_W-1:0] len_groups
);
  logic in_range;
  logic aligned;

  assign in_range   = (len >= LEN_W'(MIN_WORDS)) && (len <= LEN_W'(MAX_WORDS));
  assign aligned    = (len % LEN_W'(GROUP_WORDS)) == '0;
  assign len_ok     = in_range && aligned;
  assign len_groups = GRP_W'(len / LEN_W'(GROUP_WORDS));
endmodule

// File: rtl/blkrd_timer.sv
module blkrd_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  assert_timer_settles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (zero || !$stable(cnt_q)))
    else $error("timer stalled");
endmodule

// File: rtl/blkrd_seq.sv
module blkrd_seq
  import blkrd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BUS_WORDS   = 2,
  parameter int GROUP_WORDS = 4,
  parameter int MAX_WORDS   = 16,
  parameter int LAT_CYC     = 40,
  parameter int IDLE_CYC    = 2,
  parameter int GRP_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              len_ok,
  input  logic [GRP_W-1:0]  len_groups,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              beat,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last
);
  localparam int BEATS  = GROUP_WORDS / BUS_WORDS;
  localparam int CMAX_A = (LAT_CYC > IDLE_CYC) ? LAT_CYC : IDLE_CYC;
  localparam int CMAX   = (CMAX_A > BEATS) ? CMAX_A : BEATS;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int OFS_W  = $clog2(MAX_WORDS + 1);

  blkrd_state_e      state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [GRP_W-1:0]  grp_q;
  logic              err_q;
  logic              tm_load;
  logic [CNT_W-1:0]  tm_val;
  logic              tm_zero;
  logic              accept;
  logic              last_grp;

  blkrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .zero     (tm_zero)
  );

  assign accept   = (state_q == ST_IDLE) && start && len_ok;
  assign last_grp = (grp_q == GRP_W'(1));

  always_comb begin
    state_d = state_q;
    tm_load = 1'b0;
    tm_val  = '0;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: begin
        state_d = ST_WAIT;
        tm_load = 1'b1;
        tm_val  = CNT_W'(LAT_CYC - 1);
      end
      ST_WAIT: if (tm_zero) begin
        state_d = ST_XFER;
        tm_load = 1'b1;
        tm_val  = CNT_W'(BEATS - 1);
      end
      ST_XFER: if (tm_zero) begin
        state_d = ST_GAP;
        tm_load = 1'b1;
        tm_val  = CNT_W'(IDLE_CYC - 1);
      end
      ST_GAP: if (tm_zero) begin
        if (last_grp) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_XFER;
          tm_load = 1'b1;
          tm_val  = CNT_W'(BEATS - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ofs_q   <= '0;
      grp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_IDLE) && start && !len_ok;
      if (accept) begin
        base_q <= start_addr;
        grp_q  <= len_groups;
      end
      if (state_q == ST_ADDR) ofs_q <= '0;
      else if (state_q == ST_XFER) ofs_q <= ofs_q + OFS_W'(BUS_WORDS);
      if ((state_q == ST_GAP) && tm_zero && !last_grp) grp_q <= grp_q - 1'b1;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign err       = err_q;
  assign addr_vld  = (state_q == ST_ADDR);
  assign bus_addr  = base_q;
  assign beat      = (state_q == ST_XFER);
  assign beat_addr = base_q + ADDR_W'(ofs_q);
  assign beat_last = beat && tm_zero && last_grp;
  assign done      = (state_q == ST_GAP) && tm_zero && last_grp;

  assert_addr_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> !addr_vld)
    else $error("address strobe longer than one cycle");

  assert_beat_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat) |=> (beat && (beat_addr == $past(beat_addr) + ADDR_W'(BUS_WORDS))))
    else $error("group beats not paired or not ascending");

  assert_gap_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat) |=> !beat)
    else $error("idle gap shorter than two cycles");

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !addr_vld)
    else $error("address cycle while busy");

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !addr_vld && !beat))
    else $error("bus activity with error");

  assert_busy_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy)
    else $error("busy after done");
endmodule

// File: rtl/blkrd_ctrl.sv
module blkrd_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LEN_W       = 5,
  parameter int GROUP_WORDS = 4,
  parameter int MIN_WORDS   = 4,
  parameter int MAX_WORDS   = 16,
  parameter int LAT_CYC     = 40,
  parameter int IDLE_CYC    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [LEN_W-1:0]    start_len,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                bus_addr_vld,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_beat,
  output logic [ADDR_W-1:0]   bus_beat_addr,
  input  logic [2*WORD_W-1:0] bus_rdata,
  output logic                out_valid,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_last
);
  localparam int BUS_WORDS  = 2;
  localparam int MAX_GROUPS = MAX_WORDS / GROUP_WORDS;
  localparam int GRP_W      = $clog2(MAX_GROUPS + 1);

  logic             len_ok;
  logic [GRP_W-1:0] len_groups;
  logic             beat_last;

  blkrd_len_check #(
    .LEN_W(LEN_W), .GROUP_WORDS(GROUP_WORDS), .MIN_WORDS(MIN_WORDS),
    .MAX_WORDS(MAX_WORDS), .GRP_W(GRP_W)
  ) u_len (
    .len        (start_len),
    .len_ok     (len_ok),
    .len_groups (len_groups)
  );

  blkrd_seq #(
    .ADDR_W(ADDR_W), .BUS_WORDS(BUS_WORDS), .GROUP_WORDS(GROUP_WORDS),
    .MAX_WORDS(MAX_WORDS), .LAT_CYC(LAT_CYC), .IDLE_CYC(IDLE_CYC), .GRP_W(GRP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .len_ok     (len_ok),
    .len_groups (len_groups),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .addr_vld   (bus_addr_vld),
    .bus_addr   (bus_addr),
    .beat       (bus_beat),
    .beat_addr  (bus_beat_addr),
    .beat_last  (beat_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= bus_beat;
      out_last  <= beat_last;
      if (bus_beat) out_data <= bus_rdata;
    end
  end

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_beat && !bus_addr_vld))
    else $error("bus activity on done cycle");

  assert_last_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && !bus_beat))
    else $error("last flag without final beat");
endmodule

// File: tb/blkrd_ctrl_bench.sv
module blkrd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LEN_W = 5;
  localparam int LAT = 40;
  localparam int IDLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0] start_len = '0;
  logic busy, done, err, bus_addr_vld, bus_beat, out_valid, out_last;
  logic [ADDR_W-1:0] bus_addr, bus_beat_addr;
  logic [2*WORD_W-1:0] bus_rdata, out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkrd_ctrl #(.LAT_CYC(LAT), .IDLE_CYC(IDLE)) u_blkrd_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .err(err),
    .bus_addr_vld(bus_addr_vld), .bus_addr(bus_addr), .bus_beat(bus_beat),
    .bus_beat_addr(bus_beat_addr), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic int exp_total(input int len);
    return 1 + LAT + (len / 4) * (2 + IDLE);
  endfunction
  function automatic int exp_beat_ofs(input int k);
    return 1 + LAT + (k / 2) * (2 + IDLE) + (k % 2);
  endfunction
  function automatic bit legal(input int len);
    return (len >= 4) && (len <= 16) && (len % 4 == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cycle-counting memory: group g is readable only from offset 1+LAT+g*(2+IDLE)
  logic [ADDR_W-1:0] m_base = '0;
  int m_cnt = 0;
  always @(posedge clk) begin
    if (bus_addr_vld) begin m_base <= bus_addr; m_cnt <= 1; end
    else m_cnt <= m_cnt + 1;
  end
  always_comb begin
    int grp;
    grp = int'((bus_beat_addr - m_base) >> 2);
    if (bus_beat && m_cnt >= 1 + LAT + grp * (2 + IDLE))
      bus_rdata = {pat(bus_beat_addr + 1), pat(bus_beat_addr)};
    else
      bus_rdata = {2{32'hDEAD_BEEF}};
  end

  // Monitor state
  int cyc = 0;
  int start_cyc = -10;
  bit pend = 0;
  logic [ADDR_W-1:0] pend_addr = '0;
  int pend_len = 0;
  int cur_len = 0;
  logic [ADDR_W-1:0] base = '0;
  int t0 = 0, bk = 0, ok_k = 0, nbeats = 0;
  int done_cnt = 0, err_cnt = 0;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
    if (rst_n) begin
      if (start && !busy) start_cyc = cyc;
      if (bus_addr_vld || bus_beat || done) chk(busy, "R10", "busy during block", busy, 1);
      if (out_valid) begin
        chk(out_data == {pat(base + 2*ok_k + 1), pat(base + 2*ok_k)}, "R9", "stream data",
            out_data, {pat(base + 2*ok_k + 1), pat(base + 2*ok_k)});
        chk(out_last == (ok_k == nbeats - 1), "R9", "last flag", out_last, (ok_k == nbeats - 1));
        ok_k++;
      end
      if (bus_addr_vld) begin
        chk(pend, "R7", "unexpected address cycle", 1, pend);
        if (pend) begin
          chk(bus_addr == pend_addr, "R2", "address value", bus_addr, pend_addr);
          chk(cyc == start_cyc + 1, "R2", "address cycle timing", cyc - start_cyc, 1);
        end
        pend = 0; base = bus_addr; t0 = cyc; bk = 0; ok_k = 0;
        cur_len = pend_len; nbeats = pend_len / 2;
      end
      if (bus_beat) begin
        chk(cyc - t0 == exp_beat_ofs(bk), bk == 0 ? "R3" : "R5", "beat offset",
            cyc - t0, exp_beat_ofs(bk));
        chk(bus_beat_addr == base + 2*bk, "R4", "beat address", bus_beat_addr, base + 2*bk);
        bk++;
      end
      if (done) begin
        chk(cyc - t0 + 1 == exp_total(cur_len), "R6", "block cycles",
            cyc - t0 + 1, exp_total(cur_len));
        chk(bk == nbeats, "R4", "beat count", bk, nbeats);
        done_cnt++;
      end
      if (err) begin
        chk(cyc == start_cyc + 1, "R8", "err timing", cyc - start_cyc, 1);
        err_cnt++;
      end
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] a, input int len, input bit poke);
    int d0, e0;
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    d0 = done_cnt; e0 = err_cnt;
    start = 1'b1; start_addr = a; start_len = LEN_W'(len);
    if (legal(len)) begin pend = 1; pend_addr = a; pend_len = len; end
    @(posedge clk); #1;
    start = 1'b0;
    if (legal(len)) begin
      while (done_cnt == d0) begin
        start = poke && ($urandom % 3 == 0);
        start_addr = $urandom;
        start_len = LEN_W'(4 * (1 + $urandom % 4));
        @(posedge clk); #1;
      end
      start = 1'b0;
      @(negedge clk);
      chk(!busy, "R10", "busy low after done", busy, 0);
      chk(!out_valid, "R9", "stream quiet after block", out_valid, 0);
    end else begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(err_cnt == e0 + 1, "R8", "one err pulse", err_cnt - e0, 1);
      chk(!busy, "R8", "busy stays low", busy, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1BAD_5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1", "control idle", {busy, done, err}, 0);
    chk(!bus_addr_vld && !bus_beat, "R1", "bus idle", {bus_addr_vld, bus_beat}, 0);
    chk(!out_valid && !out_last, "R1", "stream idle", {out_valid, out_last}, 0);
    // directed corners
    run_op(32'h0000_1000, 4, 0);
    run_op(32'h0000_2000, 16, 0);
    run_op(32'hFFFF_FFF8, 8, 0);
    run_op(32'h0000_3004, 12, 1);
    run_op(32'h0000_4000, 16, 1);
    run_op(32'h0000_5000, 0, 0);
    run_op(32'h0000_5000, 3, 0);
    run_op(32'h0000_5000, 20, 0);
    run_op(32'h0000_5000, 17, 0);
    run_op(32'h0000_5000, 31, 0);
    run_op(32'h0000_5000, 6, 0);
    // constrained random mix
    for (int i = 0; i < 30; i++) begin
      int len;
      if ($urandom % 10 < 7) len = 4 * (1 + $urandom % 4);
      else len = $urandom % 32;
      run_op($urandom, len, 1'($urandom % 2));
    end
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule